// File: doc/BRIEF.md
# Configuration Store Lock Controller

This block holds the configuration image of a programmable logic core and serves a small command port. The image is made of a set of array words that record the AND-plane connections, one word of per-cell architecture bits, a 64-bit identification word and a single lock bit. Software or a programming engine issues one command at a time: a whole-store wipe, a word write, a word read-back, or setting the lock. Each command ends with a one-cycle `done` pulse. The `err` flag, when raised, marks the command as refused.

Once the lock is set, every read-back and every write is refused. This includes the identification word. The only command that clears the lock is the wipe. The wipe resets the whole image at the same time, so a locked image can never be recovered. A wipe runs for a fixed number of cycles, set by a parameter, and `busy` is high for that time. The port ignores any start strobe raised while `busy` is high.

Top module: `cfg_store_guard`

## Requirements
- R1: After reset, `busy`, `done`, `err` and `rdata` are 0 and the store is unlocked. Array words (addresses 0 to 7) read as all ones, which means every connection is open. The architecture word (address 8) and the identification word (address 9) read as zero.
- R2: A start with opcode 1 (write) or 2 (read) while idle gives `done` high in the next cycle, with `busy` low. A read returns the last word written to that address, with `err` 0.
- R3: A start with opcode 0 (wipe) while idle keeps `busy` high for exactly ERASE_CYCLES cycles. `done` then pulses, with `err` 0, in the first cycle `busy` is low. After that, every word holds its R1 value and the lock is clear.
- R4: Opcode 3 sets the lock and completes without error. While the lock is set, a read of any address completes with `err` 1 and `rdata` 0.
- R5: While the lock is set, a write (opcode 1) completes with `err` 1. After a later wipe, the target word holds its erased value, not the refused data.
- R6: Opcode 4 writes the word and then sets the lock. When the address is out of range, it completes with `err` 1 and sets no lock.
- R7: The identification word at address 9 can be written and read while unlocked. Once locked, its read is refused as in R4.
- R8: A start raised while `busy` is high produces no `done` and changes no stored word.
- R9: Opcodes 5 to 7, and reads or writes to addresses 10 and above, complete with `err` 1 and `rdata` 0. They leave the store unchanged.
- R10: `err` is high only in a cycle in which `done` is high, and `done` is never high while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command strobe, taken when `busy` is low |
| op | input | 3 | Command code (0 wipe, 1 write, 2 read, 3 lock, 4 write-and-lock) |
| addr | input | 4 | Word address |
| wdata | input | 64 | Write data |
| busy | output | 1 | Wipe in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Command refused, valid with `done` |
| rdata | output | 64 | Read result, valid with `done` |

## Verification
Two events can fall in the same cycle: the end of a wipe and the arrival of a new command. The bench holds `start` high with a write on every cycle of a wipe. It checks that no `done` appears until the wipe ends, and that none of those writes lands in the store. In the cycle where the wipe's `done` shows, it switches the held strobe to a read. It then expects that read to be accepted at once and to return the erased value.

// File: rtl/cfg_store_guard.sv
module cfg_store_guard #(
  parameter int DATA_W       = 64,
  parameter int ARR_WORDS    = 8,
  parameter int ADDR_W       = 4,
  parameter int ERASE_CYCLES = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [DATA_W-1:0] rdata
);
  localparam int NWORDS = ARR_WORDS + 2;
  localparam int CW     = $clog2(ERASE_CYCLES + 1);
  localparam logic [2:0] OP_WIPE = 3'd0, OP_WR = 3'd1, OP_RD = 3'd2,
                         OP_LOCK = 3'd3, OP_WRLOCK = 3'd4;

  logic [DATA_W-1:0] mem [NWORDS];
  logic [CW-1:0]     cnt;
  logic              secure;

  wire addr_ok = addr < ADDR_W'(NWORDS);
  wire go      = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
      rdata  <= '0;
      secure <= 1'b0;
      cnt    <= '0;
      for (int i = 0; i < NWORDS; i++) mem[i] <= (i < ARR_WORDS) ? '1 : '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (busy) begin
        if (cnt == '0) begin
          busy   <= 1'b0;
          done   <= 1'b1;
          rdata  <= '0;
          secure <= 1'b0;
          for (int i = 0; i < NWORDS; i++) mem[i] <= (i < ARR_WORDS) ? '1 : '0;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end else if (start) begin
        done  <= 1'b1;
        rdata <= '0;
        case (op)
          OP_WIPE: begin
            busy <= 1'b1;
            done <= 1'b0;
            cnt  <= CW'(ERASE_CYCLES - 1);
          end
          OP_WR, OP_WRLOCK: begin
            if (secure || !addr_ok) err <= 1'b1;
            else begin
              mem[addr] <= wdata;
              if (op == OP_WRLOCK) secure <= 1'b1;
            end
          end
          OP_RD: begin
            if (secure || !addr_ok) err <= 1'b1;
            else rdata <= mem[addr];
          end
          OP_LOCK: secure <= 1'b1;
          default: err <= 1'b1;
        endcase
      end
    end
  end

  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  a_r10_quiet_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done);
  a_r3_done_at_wipe_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && !err));
  a_r2_single_cycle_reply: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op != OP_WIPE) |=> (done && !busy));
  a_r4_locked_read_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_RD && secure) |=> (err && rdata == '0));
  a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> busy);
endmodule

// File: tb/test_cfg_store_guard.sv
module test_cfg_store_guard;
  localparam int EC = 20;
  logic clk = 0, rst_n = 0, start = 0;
  logic [2:0] op = 0;
  logic [3:0] addr = 0;
  logic [63:0] wdata = 0;
  logic busy, done, err;
  logic [63:0] rdata;
  int total = 0, bad = 0;
  logic [63:0] m_mem [10];
  logic m_sec;

  cfg_store_guard #(.ERASE_CYCLES(EC)) i_cfg_store_guard (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr),
    .wdata(wdata), .busy(busy), .done(done), .err(err), .rdata(rdata));

  always #2 clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_erase();
    for (int i = 0; i < 10; i++) m_mem[i] = (i < 8) ? '1 : '0;
    m_sec = 0;
  endtask

  task automatic cmd(logic [2:0] o, logic [3:0] a, logic [63:0] d);
    logic e_err;
    logic [63:0] e_rd;
    string tag;
    e_err = 0; e_rd = 0;
    tag = (o == 1) ? (m_sec ? "R5" : "R2") : (o == 2) ? (m_sec ? "R4" : "R2") :
          (o == 3) ? "R4" : (o == 4) ? "R6" : "R9";
    if (a == 9 && (o == 1 || o == 2)) tag = "R7";
    if (a >= 10 && o != 3) tag = "R9";
    case (o)
      3'd1, 3'd4: if (m_sec || a >= 10) e_err = 1;
                  else begin m_mem[a] = d; if (o == 4) m_sec = 1; end
      3'd2: if (m_sec || a >= 10) e_err = 1; else e_rd = m_mem[a];
      3'd3: m_sec = 1;
      default: e_err = 1;
    endcase
    @(negedge clk);
    start = 1; op = o; addr = a; wdata = d;
    @(negedge clk);
    start = 0;
    chk({tag, " done"}, done, 1);
    chk("R10 busy", busy, 0);
    chk({tag, " err"}, err, e_err);
    chk({tag, " rdata"}, rdata, e_rd);
  endtask

  task automatic wipe(bit probe);
    int n;
    @(negedge clk);
    start = 1; op = 0; addr = 0; wdata = 0;
    @(negedge clk);
    if (probe) begin op = 1; wdata = 64'h1234; end else start = 0;
    n = 0;
    while (busy && n < 1000) begin
      chk("R10 done while busy", done, 0);
      n++;
      @(negedge clk);
    end
    model_erase();
    chk("R3 busy length", n, EC);
    chk("R3 done", done, 1);
    chk("R3 err", err, 0);
    if (probe) begin
      op = 2; addr = 0;
      @(negedge clk);
      start = 0;
      chk("R8 accepted at wipe end", done, 1);
      chk("R8 no write during busy", rdata, '1);
    end else start = 0;
  endtask

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5150));
    model_erase();
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 err", err, 0);
    chk("R1 rdata", rdata, 0);
    for (int a = 0; a < 10; a++) cmd(2, 4'(a), 0);
    cmd(1, 3, 64'hDEAD_BEEF_0000_1111);
    cmd(2, 3, 0);
    cmd(1, 9, 64'hA5A5_5A5A_0F0F_F0F0);
    cmd(2, 9, 0);
    cmd(1, 8, 64'h00FF);
    cmd(2, 8, 0);
    cmd(5, 1, 0); cmd(7, 1, 0);
    cmd(1, 12, 64'h77); cmd(2, 15, 0);
    cmd(4, 11, 64'h5); cmd(2, 1, 0);
    cmd(3, 0, 0);
    cmd(2, 9, 0); cmd(2, 3, 0);
    cmd(1, 3, 64'h9999);
    wipe(0);
    cmd(2, 3, 0); cmd(2, 9, 0); cmd(2, 8, 0);
    cmd(4, 2, 64'hCAFE); cmd(2, 2, 0);
    wipe(1);
    cmd(2, 2, 0);
    for (int k = 0; k < 400; k++) begin
      int r;
      r = $urandom % 20;
      if (r == 0) wipe(($urandom % 2) == 1);
      else cmd(3'((r % 7) + 1), 4'($urandom % 12), {$urandom, $urandom});
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule